// File: doc/BRIEF.md
# Programmable Interval Timer with Reload

This block is a down-counting interval timer. Software reaches it over a small 16-bit register bus with separate write and read strobes. The count is clocked by a tick that is the system clock divided by two and then by a power-of-two prescaler. The timer can run as a periodic source that reloads itself from a modulus register. It can also run as a one-shot interval that keeps counting down through a wrap to all ones. Each time the count reaches zero, a sticky event flag is set. The interrupt line is the flag gated by an interrupt-enable bit.

The bus has three registers, selected by `bus_addr`:
- Address 0 is control/status.
- Address 1 is the modulus.
- Address 2 is the live count, which is read-only.
- Address 3 reads as zero.

Read data is registered. The value appears on `bus_rdata` one cycle after the read strobe and holds until the next read. With the direct-load mode on, a modulus write also loads the count. Software can then start a fresh interval without stopping the timer.

Top module: `intv_timer`

## Requirements
- R1: After reset the control register reads 0x0000, the modulus and count both read 0xFFFF, and `irq` is low.
- R2: Control bits [11:8] hold a prescale select s. While the run bit (control bit 0) is set, the count changes once every 2^(s+1) clock cycles. The divider restarts when run goes from 0 to 1, so the first change happens exactly 2^(s+1) cycles after the edge that set run. With s = 6 the divide is 2 x 64.
- R3: A control write that sets run while run is clear loads the count from the modulus register.
- R4: With the reload bit (control bit 1) set, a tick that finds the count at zero loads the modulus value.
- R5: With the reload bit clear, a tick that finds the count at zero wraps it to 0xFFFF, and counting continues downward.
- R6: The event flag (control bit 2) is set on every tick that leaves the count at zero.
- R7: Writing 1 to control bit 2 clears the flag, and writing 0 there leaves it unchanged. If the flag is being set in the same cycle as the clearing write, it stays set.
- R8: `irq` is high exactly while both the flag and the interrupt-enable bit (control bit 3) are set.
- R9: With the direct-load bit (control bit 4) set, a modulus write also loads the count with the written value at the same edge, and this load takes priority over a tick. With the bit clear, a modulus write leaves the count unchanged.
- R10: While run is clear, the count and the divider hold their values.
- R11: A read strobe returns the addressed register on `bus_rdata` in the next cycle, with control fields at the bit positions listed above and unused bits zero. Writes to the count address are ignored.
- R12: A modulus write without direct load during periodic operation takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register select: 0 control, 1 modulus, 2 count |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 16 | Registered read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Level interrupt, flag AND interrupt enable |

## Verification
Register writes take effect at the clock edge that samples the strobe. Read data for a strobe is due one cycle later and reflects the register contents just before that edge. `irq` follows the flag in the same cycle that the flag register changes. A count change is due at the edge that ends the cycle in which the divider reaches its limit, which is 2^(s+1) edges after the enabling write. The bench drives each access on a falling edge and advances a cycle-level expectation model at the following rising edge. It compares `bus_rdata` and `irq` on the next falling edge, so every result is sampled half a cycle after the edge that produces it.

// File: rtl/intv_pkg.sv
package intv_pkg;

  typedef enum logic [1:0] {
    A_CTRL = 2'd0,
    A_MOD  = 2'd1,
    A_CNT  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

  // control register bit positions
  localparam int unsigned B_RUN    = 0;
  localparam int unsigned B_RELOAD = 1;
  localparam int unsigned B_FLAG   = 2;
  localparam int unsigned B_IE     = 3;
  localparam int unsigned B_OVW    = 4;
  localparam int unsigned B_SEL    = 8;

  typedef struct packed {
    logic run;
    logic reload;
    logic ie;
    logic ovw;
  } mode_t;

endpackage

// File: rtl/intv_prescaler.sv
module intv_prescaler #(
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  // fixed divide by two folded in: period is 2^(sel+1)
  localparam int unsigned DIV_W = (1 << SEL_W) + 1;
  localparam logic [DIV_W-1:0] ONE   = {{(DIV_W-1){1'b0}}, 1'b1};
  localparam logic [SEL_W:0]   ONE_S = {{SEL_W{1'b0}}, 1'b1};

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_d;
  logic [DIV_W-1:0] limit;

  always_comb begin
    limit = (ONE << ({1'b0, sel} + ONE_S)) - ONE;
    tick  = run && (div_q == limit);
    if (!run) begin
      div_d = '0;
    end else if (tick) begin
      div_d = '0;
    end else begin
      div_d = div_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else begin
      div_q <= div_d;
    end
  end

endmodule

// File: rtl/intv_downcount.sv
module intv_downcount #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             reload,
  input  logic             start_load,
  input  logic [CNT_W-1:0] mod_val,
  input  logic             direct_load,
  input  logic [CNT_W-1:0] direct_val,
  output logic [CNT_W-1:0] cnt_q,
  output logic             zero_evt
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] stepped;
  logic             cnt_en;

  always_comb begin
    if (cnt_q == '0) begin
      stepped = reload ? mod_val : '1;
    end else begin
      stepped = cnt_q - ONE;
    end
    cnt_en   = start_load || direct_load || tick;
    zero_evt = 1'b0;
    if (start_load) begin
      cnt_d = mod_val;
    end else if (direct_load) begin
      cnt_d = direct_val;
    end else begin
      cnt_d    = stepped;
      zero_evt = tick && (stepped == '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/intv_regs.sv
module intv_regs
  import intv_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] cnt_q,
  input  logic             zero_evt,
  output mode_t            mode_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             flag_q,
  output logic [CNT_W-1:0] mod_q,
  output logic             start_load,
  output logic             direct_load,
  output logic [CNT_W-1:0] rdata
);

  logic             wr_ctrl;
  logic             wr_mod;
  mode_t            mode_d;
  logic             flag_d;
  logic [CNT_W-1:0] ctrl_view;
  logic [CNT_W-1:0] rd_mux;

  always_comb begin
    wr_ctrl     = wr_en && (addr == A_CTRL);
    wr_mod      = wr_en && (addr == A_MOD);
    start_load  = wr_ctrl && wdata[B_RUN] && !mode_q.run;
    direct_load = wr_mod && mode_q.ovw;

    mode_d.run    = wdata[B_RUN];
    mode_d.reload = wdata[B_RELOAD];
    mode_d.ie     = wdata[B_IE];
    mode_d.ovw    = wdata[B_OVW];

    flag_d = (flag_q && !(wr_ctrl && wdata[B_FLAG])) || zero_evt;
  end

  always_comb begin
    ctrl_view                 = '0;
    ctrl_view[B_RUN]          = mode_q.run;
    ctrl_view[B_RELOAD]       = mode_q.reload;
    ctrl_view[B_FLAG]         = flag_q;
    ctrl_view[B_IE]           = mode_q.ie;
    ctrl_view[B_OVW]          = mode_q.ovw;
    ctrl_view[B_SEL +: SEL_W] = sel_q;
    case (addr)
      A_CTRL:  rd_mux = ctrl_view;
      A_MOD:   rd_mux = mod_q;
      A_CNT:   rd_mux = cnt_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      sel_q  <= '0;
    end else if (wr_ctrl) begin
      mode_q <= mode_d;
      sel_q  <= wdata[B_SEL +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q <= '1;
    end else if (wr_mod) begin
      mod_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end

endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import intv_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq
);

  mode_t            mode_q;
  logic [SEL_W-1:0] sel_q;
  logic             flag_q;
  logic [CNT_W-1:0] mod_q;
  logic [CNT_W-1:0] cnt_q;
  logic             start_load;
  logic             direct_load;
  logic             tick;
  logic             zero_evt;

  intv_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (bus_wr),
    .rd_en       (bus_rd),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .cnt_q       (cnt_q),
    .zero_evt    (zero_evt),
    .mode_q      (mode_q),
    .sel_q       (sel_q),
    .flag_q      (flag_q),
    .mod_q       (mod_q),
    .start_load  (start_load),
    .direct_load (direct_load),
    .rdata       (bus_rdata)
  );

  intv_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (mode_q.run),
    .sel   (sel_q),
    .tick  (tick)
  );

  intv_downcount #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .reload      (mode_q.reload),
    .start_load  (start_load),
    .mod_val     (mod_q),
    .direct_load (direct_load),
    .direct_val  (bus_wdata),
    .cnt_q       (cnt_q),
    .zero_evt    (zero_evt)
  );

  assign irq = flag_q && mode_q.ie;

endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wdata,
  input logic             wr,
  input logic             tick,
  input logic             zero_evt,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] modv,
  input logic             flag,
  input logic             run,
  input logic             reload,
  input logic             ovw
);

  logic ow_write;
  assign ow_write = wr && (addr == 2'd1) && ovw;

  a_r2_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

  a_r4_reload_mod: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && reload && cnt == '0 && !ow_write) |=> (cnt == $past(modv)));

  a_r5_wrap_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reload && cnt == '0 && !ow_write) |=> (cnt == '1));

  a_r6_flag_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> (cnt == '0));

  a_r7_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == 2'd0 && wdata[2] && !zero_evt) |=> !flag);

  a_r9_direct_load: assert property (@(posedge clk) disable iff (!rst_n)
    ow_write |=> (cnt == $past(wdata)));

  a_r10_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr) |=> $stable(cnt));

endmodule

bind intv_timer intv_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .addr     (bus_addr),
  .wdata    (bus_wdata),
  .wr       (bus_wr),
  .tick     (tick),
  .zero_evt (zero_evt),
  .cnt      (cnt_q),
  .modv     (mod_q),
  .flag     (flag_q),
  .run      (mode_q.run),
  .reload   (mode_q.reload),
  .ovw      (mode_q.ovw)
);

// File: tb/sim_intv_timer.sv
module sim_intv_timer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        wr;
  logic        rd;
  logic        irq;

  always #5 clk = ~clk;

  intv_timer u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_wr    (wr),
    .bus_rd    (rd),
    .bus_rdata (rdata),
    .irq       (irq)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // expectation model state
  bit          m_run, m_rl, m_flag, m_ie, m_ow;
  logic [3:0]  m_sel;
  logic [15:0] m_mod, m_cnt;
  int          m_div;

  function automatic logic [15:0] ctrl_word();
    return {4'b0, m_sel, 3'b0, m_ow, m_ie, m_flag, m_rl, m_run};
  endfunction

  function automatic int period();
    return 2 << m_sel;
  endfunction

  function automatic logic [15:0] stepped();
    if (m_cnt == 16'h0) return m_rl ? m_mod : 16'hFFFF;
    return m_cnt - 16'h1;
  endfunction

  function automatic bit tick_now();
    return m_run && (m_div == period() - 1);
  endfunction

  function automatic bit will_set();
    return tick_now() && (stepped() == 16'h0);
  endfunction

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(bit w, bit r, logic [1:0] a, logic [15:0] d, string tag);
    logic [15:0] exp_rd;
    logic [15:0] n_cnt;
    bit          tk, set, n_flag;
    int          n_div;
    addr  = a;
    wdata = d;
    wr    = w;
    rd    = r;
    case (a)
      2'd0:    exp_rd = ctrl_word();
      2'd1:    exp_rd = m_mod;
      2'd2:    exp_rd = m_cnt;
      default: exp_rd = 16'h0;
    endcase
    tk    = tick_now();
    n_div = m_run ? (tk ? 0 : m_div + 1) : 0;
    set   = 1'b0;
    n_cnt = m_cnt;
    if (w && a == 2'd0 && d[0] && !m_run) n_cnt = m_mod;
    else if (w && a == 2'd1 && m_ow) n_cnt = d;
    else if (tk) begin
      n_cnt = stepped();
      set   = (n_cnt == 16'h0);
    end
    n_flag = (m_flag && !(w && a == 2'd0 && d[2])) || set;
    @(posedge clk);
    m_div  = n_div;
    m_cnt  = n_cnt;
    m_flag = n_flag;
    if (w && a == 2'd0) begin
      m_run = d[0]; m_rl = d[1]; m_ie = d[3]; m_ow = d[4]; m_sel = d[11:8];
    end
    if (w && a == 2'd1) m_mod = d;
    @(negedge clk);
    wr = 1'b0;
    rd = 1'b0;
    if (r) check(tag, rdata, exp_rd);
    check("R8", {15'b0, irq}, {15'b0, m_flag && m_ie});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 16'h0, "IDLE");
  endtask

  task automatic rdreg(logic [1:0] a, string tag);
    cyc(1'b0, 1'b1, a, 16'h0, tag);
  endtask

  task automatic wrreg(logic [1:0] a, logic [15:0] d, string tag);
    cyc(1'b1, 1'b0, a, d, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7391));
    rst_n = 1'b0; addr = 2'd0; wdata = 16'h0; wr = 1'b0; rd = 1'b0;
    m_run = 0; m_rl = 0; m_flag = 0; m_ie = 0; m_ow = 0;
    m_sel = 4'd0; m_mod = 16'hFFFF; m_cnt = 16'hFFFF; m_div = 0;
    repeat (3) @(negedge clk);
    check("R1", {15'b0, irq}, 16'h0);
    rst_n = 1'b1;
    // R1 reset values
    rdreg(2'd0, "R1");
    rdreg(2'd1, "R1");
    rdreg(2'd2, "R1");
    rdreg(2'd3, "R11");

    // R10 disabled: count holds
    idle(5);
    rdreg(2'd2, "R10");

    // R3 / R2 / R4 / R6 periodic, prescale 0 (period 2)
    wrreg(2'd1, 16'd5, "R11");
    wrreg(2'd0, 16'h000B, "R3");
    for (int i = 0; i < 30; i++) rdreg(2'd2, "R4");
    rdreg(2'd0, "R6");

    // R12 modulus change without direct load takes effect at reload
    wrreg(2'd1, 16'd2, "R12");
    for (int i = 0; i < 24; i++) rdreg(2'd2, "R12");

    // R7 clear with no concurrent set
    while (will_set()) idle(1);
    wrreg(2'd0, 16'h000F, "R7");
    rdreg(2'd0, "R7");
    // R7 clear coinciding with a set: flag stays
    for (int i = 0; i < 40; i++) begin
      if (will_set()) begin
        wrreg(2'd0, 16'h000F, "R7");
        break;
      end
      idle(1);
    end
    rdreg(2'd0, "R7");

    // R8 interrupt enable gating
    wrreg(2'd0, 16'h0003, "R8");
    rdreg(2'd0, "R8");

    // R5 one-shot wrap
    wrreg(2'd0, 16'h0000, "R10");
    wrreg(2'd1, 16'd3, "R5");
    wrreg(2'd0, 16'h0009, "R5");
    for (int i = 0; i < 14; i++) rdreg(2'd2, "R5");

    // R9 direct load while running, then without direct load
    wrreg(2'd0, 16'h0004, "R10");
    wrreg(2'd0, 16'h0019, "R9");
    wrreg(2'd1, 16'd40, "R9");
    rdreg(2'd2, "R9");
    wrreg(2'd0, 16'h0009, "R9");
    wrreg(2'd1, 16'd7, "R9");
    rdreg(2'd2, "R9");

    // R11 writes to count address ignored
    wrreg(2'd2, 16'h1234, "R11");
    rdreg(2'd2, "R11");
    rdreg(2'd1, "R11");

    // R10 stop holds count
    wrreg(2'd0, 16'h0000, "R10");
    idle(9);
    rdreg(2'd2, "R10");

    // R2 divide by 2 x 64
    wrreg(2'd1, 16'd100, "R2");
    wrreg(2'd0, 16'h0601, "R2");
    for (int i = 0; i < 300; i++) rdreg(2'd2, "R2");

    // random mix
    wrreg(2'd0, 16'h0000, "RND");
    for (int i = 0; i < 4000; i++) begin
      int unsigned op;
      logic [15:0] v;
      op = $urandom % 10;
      v  = 16'($urandom);
      case (op)
        0: begin
          v[11:8] = 4'($urandom % 3);
          wrreg(2'd0, v, "RND");
        end
        1: wrreg(2'd1, 16'($urandom % 12), "RND");
        2: wrreg(2'd2, v, "R11");
        3, 4, 5, 6: rdreg(2'($urandom % 4), "RND");
        default: idle(1);
      endcase
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule